// File: doc/BRIEF.md
# CRC-4 Submultiframe Generator and Checker

This block adds and verifies the four-bit cyclic check that protects each submultiframe of a 2048 kbit/s E1 stream. It works one bit at a time. The framer supplies a bit-enable strobe, a frame-start strobe on the first bit of every frame, and a multiframe-start strobe on the first bit of the first frame of each sixteen-frame CRC multiframe. From these strobes the block keeps its own count of the frame number.

A submultiframe is eight frames, and a CRC multiframe is two submultiframes. The check value for a submultiframe is found in three steps: treat the bits of that submultiframe as one binary number, with the four check-bit positions read as zero; multiply by x^4; divide by x^4 + x + 1. The four-bit remainder is the check value.

On transmit, the block places the remainder of the previous submultiframe into the first bit of the four alignment frames of the current one. It also inserts two far-end report bits, taken from an input port, into the first bit of the last two odd frames of the multiframe. On receive, it computes the same remainder and compares it with the check bits that arrive in the following submultiframe. It raises a one-cycle error pulse on a mismatch and counts errored submultiframes in a saturating counter.

Top module: `crc4_smf_checker`

## Requirements
- R1: At each submultiframe boundary, the remainder of the submultiframe just finished is computed: its bits with check positions read as zero, multiplied by x^4, modulo x^4 + x + 1. The remainder is sent on `txBitOut` in the first bit of frames 0, 2, 4 and 6 of the next submultiframe, most significant bit first. Frame numbers here count within the submultiframe.
- R2: The value of `txBitIn` during a check-bit position never reaches `txBitOut`, and it does not affect any remainder.
- R3: On every bit that is neither a check position nor a report position, `txBitOut` equals `txBitIn`. This also holds on every cycle where `bitEn` is low.
- R4: The first bit of multiframe frame 13 carries `eBitsIn[0]` and the first bit of frame 15 carries `eBitsIn[1]`. These inserted values are the ones covered by the transmit remainder.
- R5: On receive, the four bits collected at the check positions of a submultiframe, first received as most significant, are compared with the remainder of the previous submultiframe. On a mismatch, `smfErr` is high for exactly the one cycle after the fourth check bit was taken.
- R6: No comparison is made in the first submultiframe after reset. The bits in its check positions cause no error pulse.
- R7: `errCount` increments by one with each error pulse, stays put otherwise, and holds at its all-ones maximum.
- R8: While `bitEn` is low, the frame strobes and data inputs have no effect on any state.
- R9: During and after reset, `smfErr` and `errCount` are zero and the transmit remainder is zero.
- R10: A multiframe-start strobe forces the frame count back to frame 0 and starts a new submultiframe, even in the middle of a multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | The current cycle carries one line bit |
| frameStart | input | 1 | The current bit is the first bit of a frame |
| mfStart | input | 1 | The current bit is the first bit of a CRC multiframe |
| txBitIn | input | 1 | Outgoing payload bit |
| rxBitIn | input | 1 | Incoming line bit |
| eBitsIn | input | 2 | Far-end report bits for frames 13 and 15 |
| txBitOut | output | 1 | Outgoing line bit with check and report bits inserted |
| smfErr | output | 1 | One-cycle pulse for an errored received submultiframe |
| errCount | output | CNT_W | Saturating count of errored submultiframes |

## Verification
The embedded properties watch, on every cycle, that the frame count freezes while bits are gated off, that an error pulse is one cycle wide and only follows the fourth received check bit, and that the counter moves only with a pulse and holds at its ceiling. Only the bench scenarios can show that the remainder values are correct and are placed in the right slots. The same holds for the report-bit insertion, for the quiet first submultiframe, for detection of corrupted check words, and for realignment on an early multiframe strobe. The bench checks these against a long-division model of its own.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  localparam int CRC_W = 4;
  localparam int IDX_W = $clog2(CRC_W);

  typedef struct packed {
    logic             shift;
    logic             smfBound;
    logic             crcSlot;
    logic [IDX_W-1:0] crcIdx;
    logic             eSlot;
    logic             eSel;
  } crcStrobeT;
endpackage

// File: rtl/crc4_ctrl.sv
module crc4_ctrl
  import crc4_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      frameStart,
  input  logic      mfStart,
  output crcStrobeT st
);
  localparam int SMF_FRAMES = 2 * CRC_W;
  localparam int MF_FRAMES  = 2 * SMF_FRAMES;
  localparam int FR_W       = $clog2(MF_FRAMES);
  localparam int SMF_W      = $clog2(SMF_FRAMES);

  logic [FR_W-1:0] frameCnt;
  logic [FR_W-1:0] curFrame;
  logic            firstBit;

  always_comb begin
    curFrame = frameCnt;
    if (frameStart) curFrame = mfStart ? '0 : frameCnt + 1'b1;
  end

  assign firstBit = bitEn && frameStart;

  always_ff @(posedge clk) begin
    if (!rstN) frameCnt <= '1;
    else if (firstBit) frameCnt <= curFrame;
  end

  always_comb begin
    st.shift    = bitEn;
    st.smfBound = firstBit && (curFrame[SMF_W-1:0] == '0);
    st.crcSlot  = firstBit && !curFrame[0];
    st.crcIdx   = curFrame[IDX_W:1];
    st.eSlot    = firstBit && (curFrame == FR_W'(MF_FRAMES-3) || curFrame == FR_W'(MF_FRAMES-1));
    st.eSel     = (curFrame == FR_W'(MF_FRAMES-1));
  end

  // R8: gated-off cycles leave the frame position untouched
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(frameCnt));
endmodule

// File: rtl/crc4_datapath.sv
module crc4_datapath
  import crc4_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY  = 4'b0011,
  parameter int               CNT_W = 10
)(
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobeT        st,
  input  logic             txBitIn,
  input  logic             rxBitIn,
  input  logic [1:0]       eBitsIn,
  output logic             txBitOut,
  output logic             smfErr,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_W-1);

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crc, input logic b);
    logic fb;
    fb = b ^ crc[CRC_W-1];
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  logic [CRC_W-1:0] txCrc, txHeld, txRem;
  logic [CRC_W-1:0] rxCrc, rxExp, rxCheck, rxGot;
  logic             lineBit, txFeed, rxFeed;
  logic             primed, expValid, lastSlot, mismatch;

  // transmit path
  assign lineBit  = st.eSlot ? eBitsIn[st.eSel] : txBitIn;
  assign txRem    = st.smfBound ? txCrc : txHeld;
  assign txBitOut = st.crcSlot ? txRem[LAST_IDX - st.crcIdx] : lineBit;
  assign txFeed   = st.crcSlot ? 1'b0 : lineBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCrc  <= '0;
      txHeld <= '0;
    end else if (st.shift) begin
      txCrc <= crcStep(st.smfBound ? '0 : txCrc, txFeed);
      if (st.smfBound) txHeld <= txCrc;
    end
  end

  // receive path
  assign rxFeed   = st.crcSlot ? 1'b0 : rxBitIn;
  assign rxGot    = {rxCheck[CRC_W-2:0], rxBitIn};
  assign lastSlot = st.crcSlot && (st.crcIdx == LAST_IDX);
  assign mismatch = expValid && (rxGot != rxExp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCrc    <= '0;
      rxExp    <= '0;
      rxCheck  <= '0;
      primed   <= 1'b0;
      expValid <= 1'b0;
      smfErr   <= 1'b0;
      errCount <= '0;
    end else begin
      smfErr <= 1'b0;
      if (st.shift) begin
        rxCrc <= crcStep(st.smfBound ? '0 : rxCrc, rxFeed);
        if (st.smfBound) begin
          rxExp    <= rxCrc;
          primed   <= 1'b1;
          expValid <= primed;
        end
        if (st.crcSlot) rxCheck <= rxGot;
        if (lastSlot && mismatch) begin
          smfErr <= 1'b1;
          if (errCount != CNT_MAX) errCount <= errCount + 1'b1;
        end
      end
    end
  end

  // R5: a pulse lasts one cycle
  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    smfErr |=> !smfErr);
  // R5: a pulse only follows the last received check bit
  assert_err_after_c4_R5: assert property (@(posedge clk) disable iff (!rstN)
    smfErr |-> $past(st.shift && st.crcSlot && st.crcIdx == LAST_IDX));
  // R7: counter moves only with a pulse
  assert_count_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !smfErr |-> $stable(errCount));
  // R7: counter holds at its ceiling
  assert_count_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX) |=> (errCount == CNT_MAX));
endmodule

// File: rtl/crc4_smf_checker.sv
module crc4_smf_checker
  import crc4_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY  = 4'b0011,
  parameter int               CNT_W = 10
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             frameStart,
  input  logic             mfStart,
  input  logic             txBitIn,
  input  logic             rxBitIn,
  input  logic [1:0]       eBitsIn,
  output logic             txBitOut,
  output logic             smfErr,
  output logic [CNT_W-1:0] errCount
);
  crcStrobeT st;

  crc4_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn),
    .frameStart(frameStart), .mfStart(mfStart), .st(st)
  );

  crc4_datapath #(.POLY(POLY), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .txBitIn(txBitIn), .rxBitIn(rxBitIn), .eBitsIn(eBitsIn),
    .txBitOut(txBitOut), .smfErr(smfErr), .errCount(errCount)
  );
endmodule

// File: tb/crc4_smf_checker_test.sv
module crc4_smf_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 256;
  localparam int CNT_W      = 3;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int RUN_MF     = 10;

  logic clk = 1'b0;
  logic rstN, bitEn, frameStart, mfStart, txBitIn, rxBitIn;
  logic [1:0] eBitsIn;
  logic txBitOut, smfErr;
  logic [CNT_W-1:0] errCount;

  crc4_smf_checker #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .mfStart(mfStart), .txBitIn(txBitIn), .rxBitIn(rxBitIn),
    .eBitsIn(eBitsIn), .txBitOut(txBitOut), .smfErr(smfErr),
    .errCount(errCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // model state
  int bitPos = 0, frameNo = 0, mfNo = 0, smfIdx = 0, cycle = 0;
  bit txQ[$];
  bit rxQ[$];
  logic [3:0] txPrev = 4'h0, rxExpM = 4'h0, rxSend = 4'hF, rxGotM = 4'h0;
  bit valid = 0, expErr = 0, expTx = 0, jumped = 0;
  int expCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycle);
    end
  endtask

  function automatic logic [3:0] remOf(input bit q[$]);
    logic [4:0] r = 5'd0;
    foreach (q[i]) begin
      r = {r[3:0], q[i]};
      if (r[4]) r ^= 5'b10011;
    end
    for (int k = 0; k < 4; k++) begin
      r = {r[3:0], 1'b0};
      if (r[4]) r ^= 5'b10011;
    end
    return r[3:0];
  endfunction

  function automatic bit isCSlot();
    return bitPos == 0 && (frameNo % 2 == 0);
  endfunction
  function automatic int cIdx();
    return (frameNo % 8) / 2;
  endfunction
  function automatic bit isESlot();
    return bitPos == 0 && (frameNo == 13 || frameNo == 15);
  endfunction

  task automatic finalize();
    txPrev = remOf(txQ);
    rxExpM = remOf(rxQ);
    valid  = 1;
    smfIdx++;
    rxSend = rxExpM ^ ((smfIdx >= 3 && smfIdx % 2 == 1) ? 4'b0010 : 4'b0000);
    txQ.delete();
    rxQ.delete();
  endtask

  task automatic drive();
    bitEn = !(mfNo >= 3 && mfNo <= 4 && cycle % 3 == 2);
    frameStart = (bitPos == 0);
    mfStart = (bitPos == 0 && frameNo == 0);
    txBitIn = 1'($urandom_range(0, 1));
    if (bitPos == 0 && frameNo == 0) eBitsIn = 2'($urandom_range(0, 3));
    rxBitIn = isCSlot() ? rxSend[3 - cIdx()] : 1'($urandom_range(0, 1));
    if (bitEn && isCSlot()) expTx = txPrev[3 - cIdx()];
    else if (bitEn && isESlot()) expTx = eBitsIn[frameNo == 15];
    else expTx = txBitIn;
  endtask

  task automatic process();
    bit line, newErr;
    expErr = 0;
    if (!bitEn) return;
    line = isESlot() ? eBitsIn[frameNo == 15] : txBitIn;
    txQ.push_back(isCSlot() ? 1'b0 : line);
    rxQ.push_back(isCSlot() ? 1'b0 : rxBitIn);
    if (isCSlot()) begin
      rxGotM = {rxGotM[2:0], rxBitIn};
      if (cIdx() == 3) begin
        newErr = valid && (rxGotM != rxExpM);
        expErr = newErr;
        if (newErr && expCnt < CNT_MAX) expCnt++;
      end
    end
    // advance position
    if (mfNo == 6 && frameNo == 5 && bitPos == FRAME_BITS-1 && !jumped) begin
      // R10: early multiframe start mid-submultiframe
      jumped = 1;
      bitPos = 0; frameNo = 0; mfNo++;
      finalize();
    end else if (bitPos == FRAME_BITS-1) begin
      bitPos = 0;
      if (frameNo % 8 == 7) finalize();
      if (frameNo == 15) begin frameNo = 0; mfNo++; end
      else frameNo++;
    end else bitPos++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; bitEn = 0; frameStart = 0; mfStart = 0;
    txBitIn = 1; rxBitIn = 0; eBitsIn = 2'b00;
    repeat (4) begin
      @(negedge clk);
      check(smfErr == 1'b0, "R9 smfErr in reset", smfErr, 0);
      check(errCount == '0, "R9 errCount in reset", errCount, 0);
      check(txBitOut == txBitIn, "R3 tx pass in reset", txBitOut, txBitIn);
    end
    rstN = 1;
    drive();
    #1 check(txBitOut == expTx, "R1 R9 first remainder bit", txBitOut, expTx);
    while (mfNo < RUN_MF) begin
      @(negedge clk);
      cycle++;
      process();
      check(smfErr == expErr, "R5 R6 error pulse", smfErr, expErr);
      check(int'(errCount) == expCnt, "R7 error count", errCount, expCnt);
      drive();
      #1;
      if (bitEn && isCSlot())
        check(txBitOut == expTx, "R1 R2 check bit", txBitOut, expTx);
      else if (bitEn && isESlot())
        check(txBitOut == expTx, "R4 report bit", txBitOut, expTx);
      else
        check(txBitOut == expTx, "R3 R8 payload pass", txBitOut, expTx);
    end
    check(expCnt == CNT_MAX, "R7 saturation reached", expCnt, CNT_MAX);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule